// File: doc/BRIEF.md
# Multiprocessor-Mode UART Receiver

This block is an asynchronous serial receiver with an address/data mode for shared multi-drop lines. The line is oversampled 16 times per bit. A fixed clock divider sets the oversampling rate. An optional three-sample majority filter can clean the line before bits are sampled. A one-shot write port loads a control word. In multiprocessor mode every frame carries one extra bit after the data byte, and that bit marks the frame as an address (1) or data (0) frame.

Software sets a wait-for-address flag so that a station ignores traffic that is not meant for it. While the flag is set and multiprocessor mode is on, the receiver drops data frames without a trace. No receive-complete, overrun or framing-error indication is raised for them. The first address frame clears the flag in hardware. That frame and the frames after it are delivered normally, and the extra bit is stored next to the byte so the reader can tell what it holds.

A reader polls `rx_done`, takes `rx_data` and `rx_mpb`, and pulses `rx_rd` to acknowledge the frame. The acknowledge also clears the error flags.

Top module: `mpuart_rx`

## Requirements
- R1: After a synchronous reset, every control bit is 0, so multiprocessor mode, parity and the filter are off. `addr_wait`, `rx_done`, `rx_ovr`, `rx_ferr`, `rx_perr`, `rx_mpb` are 0 and `rx_data` is 0x00.
- R2: With multiprocessor mode and parity off, a frame is one low start bit, 8 data bits LSB first, then one stop bit. Each bit lasts 16 ticks and is sampled at its middle. A received frame sets `rx_done` and places the byte on `rx_data` with `rx_mpb` = 0.
- R3: Control bit 0 (`mp_en`) = 1 adds one multiprocessor bit after the data bits. Its value appears on `rx_mpb`. Control bits 2 (parity enable) and 3 (parity odd) are then ignored: the frame stays 11 bits and `rx_perr` stays 0.
- R4: With `mp_en` = 1 and control bit 1 (`addr_wait`) = 1, a frame whose multiprocessor bit is 0 is discarded. `rx_done`, `rx_ovr`, `rx_ferr`, `rx_perr` and `rx_data` do not change, even if the stop bit is low or an unread byte is pending.
- R5: With `mp_en` = 1 and `addr_wait` = 1, a frame whose multiprocessor bit is 1 clears `addr_wait` and is delivered with `rx_mpb` = 1. Later data frames are delivered.
- R6: With `mp_en` = 0, `addr_wait` has no effect: frames are delivered and the flag keeps its written value.
- R7: Control bit 5 (`sync_sel`) = 1 forces multiprocessor mode and the noise filter off, whatever their control bits hold.
- R8: A stop bit that samples low sets `rx_ferr` together with `rx_done` for that frame. A high stop bit clears it.
- R9: A frame that completes while `rx_done` is still set raises `rx_ovr` and keeps the earlier byte. A one-cycle `rx_rd` pulse clears `rx_done`, `rx_ovr`, `rx_ferr` and `rx_perr`.
- R10: With multiprocessor mode off and control bit 2 (parity enable) = 1, one parity bit follows the data. Control bit 3 = 0 selects even parity and 1 selects odd parity. A mismatch sets `rx_perr`.
- R11: With control bit 4 (filter enable) = 1, the line goes through a majority vote of three consecutive tick samples. A glitch one tick long inside a bit does not change the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| ctl_we | input | 1 | Loads `ctl_wdata` into the control word |
| ctl_wdata | input | 6 | Control word: [0] mp_en, [1] addr_wait, [2] parity enable, [3] parity odd, [4] filter enable, [5] sync_sel |
| rx_rd | input | 1 | Acknowledge pulse, clears receive and error flags |
| rx_data | output | 8 | Last delivered byte |
| rx_mpb | output | 1 | Multiprocessor bit of the last delivered frame |
| rx_done | output | 1 | Receive-complete flag |
| rx_ovr | output | 1 | Overrun flag |
| rx_ferr | output | 1 | Framing error flag |
| rx_perr | output | 1 | Parity error flag |
| addr_wait | output | 1 | Current wait-for-address flag |

## Verification
A wait flag that sticks high shows up one frame time after an address frame: `rx_done` stays low and `addr_wait` still reads 1. A wait flag that is cleared too early lets a data frame raise `rx_done`. A wrong bit counter or wrong sampling phase corrupts `rx_data`, `rx_mpb` or `rx_ferr` at the end of the same frame, within about eleven bit times. A broken filter history flips bits in glitched frames. Because every flag is compared after every frame, a fault is reported at the first frame that exposes it.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

    localparam int DATA_W = 8;
    localparam int OVS    = 16;
    localparam int OVS_W  = $clog2(OVS);
    localparam int MID    = OVS / 2 - 1;
    localparam int IDX_W  = $clog2(DATA_W);

    typedef struct packed {
        logic sync_sel;
        logic filt_en;
        logic par_odd;
        logic par_en;
        logic wait_addr;
        logic mp_en;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_EXTRA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              xbit;
        logic              stop_ok;
    } frame_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              done;
        logic              ovr;
        logic              ferr;
        logic              perr;
    } stat_t;

    function automatic logic maj3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

    function automatic logic parity_bad(input logic [DATA_W-1:0] d,
                                        input logic pbit, input logic odd);
        return ((^d) ^ pbit) != odd;
    endfunction

endpackage

// File: rtl/mpuart_tick.sv
module mpuart_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CNT_W'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end

    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && tick) |=> !tick);

endmodule

// File: rtl/mpuart_filter.sv
module mpuart_filter (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic din,
    input  logic filt_en,
    output logic dout
);
    import mpuart_pkg::*;

    logic [1:0] sync_q;
    logic [2:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            hist   <= 3'b111;
        end else begin
            sync_q <= {sync_q[0], din};
            if (tick) hist <= {hist[1:0], sync_q[1]};
        end
    end

    assign dout = filt_en ? maj3(hist) : hist[0];

    // R11
    filt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (filt_en && $past(filt_en) && !$past(tick)) |-> $stable(dout));

endmodule

// File: rtl/mpuart_frame.sv
module mpuart_frame (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   rxd,
    input  logic   has_x,
    output mpuart_pkg::frame_t frm,
    output logic   frm_vld
);
    import mpuart_pkg::*;

    rx_state_e         st;
    logic [OVS_W-1:0]  ocnt;
    logic [IDX_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;
    logic              xb;

    wire last_tick = (ocnt == OVS_W'(OVS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            ocnt    <= '0;
            bidx    <= '0;
            sh      <= '0;
            xb      <= 1'b0;
            frm     <= '0;
            frm_vld <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: begin
                        if (!rxd) begin
                            st   <= ST_START;
                            ocnt <= '0;
                            xb   <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (ocnt == OVS_W'(MID)) begin
                            ocnt <= '0;
                            bidx <= '0;
                            st   <= rxd ? ST_IDLE : ST_DATA;
                        end else begin
                            ocnt <= ocnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        ocnt <= ocnt + 1'b1;
                        if (last_tick) begin
                            sh   <= {rxd, sh[DATA_W-1:1]};
                            bidx <= bidx + 1'b1;
                            if (bidx == IDX_W'(DATA_W - 1))
                                st <= has_x ? ST_EXTRA : ST_STOP;
                        end
                    end
                    ST_EXTRA: begin
                        ocnt <= ocnt + 1'b1;
                        if (last_tick) begin
                            xb <= rxd;
                            st <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        ocnt <= ocnt + 1'b1;
                        if (last_tick) begin
                            frm     <= '{data: sh, xbit: xb, stop_ok: rxd};
                            frm_vld <= 1'b1;
                            st      <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2
    vld_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frm_vld |=> !frm_vld);

    // R2
    vld_from_stop_chk: assert property (@(posedge clk) disable iff (rst)
        frm_vld |-> $past(st) == ST_STOP);

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    input  logic       ctl_we,
    input  logic [5:0] ctl_wdata,
    input  logic       rx_rd,
    output logic [7:0] rx_data,
    output logic       rx_mpb,
    output logic       rx_done,
    output logic       rx_ovr,
    output logic       rx_ferr,
    output logic       rx_perr,
    output logic       addr_wait
);
    import mpuart_pkg::*;

    ctl_t   ctl_q;
    stat_t  st_q;
    frame_t frm;
    logic   frm_vld, tick, line;

    wire mp_eff   = ctl_q.mp_en & ~ctl_q.sync_sel;
    wire filt_eff = ctl_q.filt_en & ~ctl_q.sync_sel;
    wire par_eff  = ctl_q.par_en & ~mp_eff;
    wire has_x    = mp_eff | par_eff;
    wire discard  = frm_vld & mp_eff & ctl_q.wait_addr & ~frm.xbit;
    wire accept   = frm_vld & ~discard;

    mpuart_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

    mpuart_filter u_filt (
        .clk(clk), .rst(rst), .tick(tick), .din(rxd),
        .filt_en(filt_eff), .dout(line)
    );

    mpuart_frame u_frame (
        .clk(clk), .rst(rst), .tick(tick), .rxd(line),
        .has_x(has_x), .frm(frm), .frm_vld(frm_vld)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_t'(ctl_wdata);
        end else if (accept && mp_eff && ctl_q.wait_addr) begin
            ctl_q.wait_addr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (accept) begin
            if (st_q.done && !rx_rd) begin
                st_q.ovr <= 1'b1;
            end else begin
                st_q.data <= frm.data;
                st_q.mpb  <= mp_eff & frm.xbit;
                st_q.done <= 1'b1;
                st_q.ovr  <= 1'b0;
                st_q.ferr <= ~frm.stop_ok;
                st_q.perr <= par_eff & parity_bad(frm.data, frm.xbit, ctl_q.par_odd);
            end
        end else if (rx_rd) begin
            st_q.done <= 1'b0;
            st_q.ovr  <= 1'b0;
            st_q.ferr <= 1'b0;
            st_q.perr <= 1'b0;
        end
    end

    assign rx_data   = st_q.data;
    assign rx_mpb    = st_q.mpb;
    assign rx_done   = st_q.done;
    assign rx_ovr    = st_q.ovr;
    assign rx_ferr   = st_q.ferr;
    assign rx_perr   = st_q.perr;
    assign addr_wait = ctl_q.wait_addr;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (ctl_q == '0) && !rx_done && !rx_ovr && !rx_ferr && !rx_perr);

    // R4
    discard_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (discard && !rx_rd) |=> $stable(rx_done) && $stable(rx_ovr) &&
            $stable(rx_ferr) && $stable(rx_perr) && $stable(rx_data));

    // R5
    addr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && mp_eff && ctl_q.wait_addr && frm.xbit && !ctl_we)
            |=> !addr_wait && rx_done);

    // R3
    mp_no_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && mp_eff && !ctl_q.wait_addr && !rx_done) |=> !rx_perr);

    // R7
    sync_no_mpb_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && ctl_q.sync_sel && !rx_done) |=> rx_done && !rx_mpb);

    // R9
    overrun_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && rx_done && !rx_rd) |=> rx_ovr && $stable(rx_data));

endmodule

// File: tb/mpuart_rx_test.sv
module mpuart_rx_test;

    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       ctl_we = 1'b0;
    logic [5:0] ctl_wdata = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       rx_mpb, rx_done, rx_ovr, rx_ferr, rx_perr, addr_wait;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bench-side model
    logic [5:0] cfg = '0;
    logic [7:0] e_data = '0;
    logic e_mpb = 0, e_done = 0, e_ovr = 0, e_ferr = 0, e_perr = 0, e_wait = 0;

    always #5 clk = ~clk;

    mpuart_rx #(.DIV(DIV)) uut (
        .clk(clk), .rst(rst), .rxd(rxd), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .rx_rd(rx_rd), .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_done(rx_done),
        .rx_ovr(rx_ovr), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .addr_wait(addr_wait)
    );

    function automatic logic mp_on();
        return cfg[0] & ~cfg[5];
    endfunction

    function automatic logic par_on();
        return cfg[2] & ~mp_on();
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk(tag, "rx_done", 8'(rx_done), 8'(e_done));
        chk(tag, "rx_data", rx_data, e_data);
        chk(tag, "rx_mpb", 8'(rx_mpb), 8'(e_mpb));
        chk(tag, "rx_ovr", 8'(rx_ovr), 8'(e_ovr));
        chk(tag, "rx_ferr", 8'(rx_ferr), 8'(e_ferr));
        chk(tag, "rx_perr", 8'(rx_perr), 8'(e_perr));
        chk(tag, "addr_wait", 8'(addr_wait), 8'(e_wait));
    endtask

    task automatic wr_ctl(input logic [5:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        cfg = v;
        e_wait = v[1];
    endtask

    task automatic do_read();
        @(negedge clk);
        rx_rd = 1'b1;
        @(negedge clk);
        rx_rd = 1'b0;
        e_done = 0; e_ovr = 0; e_ferr = 0; e_perr = 0;
    endtask

    // model of one frame arriving
    task automatic model(input logic [7:0] d, input logic xb, input logic stop);
        logic mp, par;
        mp = mp_on();
        par = par_on();
        if (mp && e_wait && !xb) return;
        if (mp && e_wait) e_wait = 0;
        if (e_done) begin
            e_ovr = 1;
        end else begin
            e_data = d;
            e_mpb = mp & xb;
            e_done = 1;
            e_ferr = ~stop;
            e_perr = par & (((^d) ^ xb) != cfg[3]);
        end
    endtask

    // drives a frame in the current format; glitch=1 puts a one-tick glitch in each data bit
    task automatic send(input logic [7:0] d, input logic xb, input logic stop,
                        input bit glitch);
        logic [10:0] bits;
        int n;
        n = (mp_on() || par_on()) ? 11 : 10;
        bits = '1;
        bits[0] = 1'b0;
        bits[8:1] = d;
        if (n == 11) begin
            bits[9] = xb;
            bits[10] = stop;
        end else begin
            bits[9] = stop;
        end
        for (int i = 0; i < n; i++) begin
            for (int c = 0; c < BIT; c++) begin
                @(negedge clk);
                rxd = bits[i];
                if (glitch && i >= 1 && i <= 8 &&
                    c >= 10 + 2 * (i % 5) && c < 10 + 2 * (i % 5) + DIV)
                    rxd = ~bits[i];
            end
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        model(d, (n == 11) ? xb : 1'b0, stop);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk_all("R1");

        // R2 plain frames, LSB first
        send(8'hA5, 0, 1, 0); chk_all("R2"); do_read();
        send(8'h3C, 0, 1, 0); chk_all("R2"); do_read(); chk_all("R2");

        // R8 framing error, then a clean frame clears it
        send(8'h81, 0, 0, 0); chk_all("R8"); do_read();
        send(8'h7E, 0, 1, 0); chk_all("R8"); do_read();

        // R9 overrun keeps first byte, read clears
        send(8'h11, 0, 1, 0);
        send(8'h22, 0, 0, 0); chk_all("R9");
        do_read(); chk_all("R9");

        // R10 parity even then odd
        wr_ctl(6'b000100);
        send(8'h03, 0, 1, 0); chk_all("R10"); do_read();
        send(8'h03, 1, 1, 0); chk_all("R10"); do_read();
        wr_ctl(6'b001100);
        send(8'h07, 0, 1, 0); chk_all("R10"); do_read();
        send(8'h07, 1, 1, 0); chk_all("R10"); do_read();

        // R3 multiprocessor mode with parity bits set: parity ignored
        wr_ctl(6'b001101);
        send(8'h5A, 1, 1, 0); chk_all("R3"); do_read();
        send(8'h01, 0, 1, 0); chk_all("R3"); do_read();

        // R4 data frames discarded while waiting, incl. bad stop and pending byte
        wr_ctl(6'b000011);
        send(8'h44, 0, 1, 0); chk_all("R4");
        send(8'h45, 0, 0, 0); chk_all("R4");
        wr_ctl(6'b000001);
        send(8'h99, 1, 1, 0);
        wr_ctl(6'b000011);
        send(8'h46, 0, 0, 0); chk_all("R4");
        do_read();

        // R5 address frame clears the flag; later data frames delivered
        send(8'hC3, 1, 1, 0); chk_all("R5"); do_read();
        send(8'h12, 0, 1, 0); chk_all("R5"); do_read();

        // R6 wait flag ignored with multiprocessor mode off
        wr_ctl(6'b000010);
        send(8'h6D, 0, 1, 0); chk_all("R6"); do_read();

        // R7 sync select forces mp and filter off
        wr_ctl(6'b110011);
        send(8'hE4, 0, 1, 0); chk_all("R7"); do_read();

        // R11 filter rejects one-tick glitches
        wr_ctl(6'b010000);
        send(8'hB6, 0, 1, 1); chk_all("R11"); do_read();
        send(8'h49, 0, 1, 1); chk_all("R11"); do_read();

        // random traffic in multiprocessor mode (R3 R4 R5 R9)
        void'($urandom(32'd1234));
        for (int k = 0; k < 40; k++) begin
            logic [7:0] d;
            logic xb, stop, filt;
            d = 8'($urandom);
            xb = 1'($urandom);
            stop = ($urandom % 8) != 0;
            filt = 1'($urandom);
            if (($urandom % 4) == 0) wr_ctl({1'b0, filt, 2'b00, 1'($urandom), 1'b1});
            send(d, xb, stop, cfg[4]);
            chk_all("R4_R5_rand");
            if (($urandom % 3) != 0) do_read();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule